// File: doc/BRIEF.md
# Radix Page Table Walker

This block translates an address by walking a multi-level radix page table held in memory. A request supplies the root table base, the root table's next-level size (log2 of its entry count), the total translated size in bits and the address to translate. From the root down, the walker derives the index for each level, reads the 64-bit entry over a single memory port and checks it. A directory entry gives the next table's base and its own next-level size, so the index width can change from level to level. The walk stops at a leaf entry.

On a leaf the walker forms the real address and the page size. It then sets the reference bit, and on a store also the change bit. It writes the entry back to the address it was read from, but only when a bit actually changed. A walk ends with a one-cycle done pulse, or with a one-cycle fault pulse and cause bits. Any memory access may stall for any number of cycles.

Top module: `radix_walker`

## Requirements
- R1: After reset `ready_o` is 1, and `done_o`, `fault_o` and `mem_req_o` are 0.
- R2: At each level the remaining size is first reduced by the current next-level size. The index is the address shifted right by that remaining size and masked to next-level-size bits. The read address is the table base plus 8 times the index. The root level uses `root_base_i` and `root_nls_i`. A directory entry supplies the next base as `{8'h0, entry[55:8], 8'h00}` and the next-level size as `entry[4:0]`.
- R3: A next-level size below 5 at any level ends the walk with a fault whose cause is 2'b01 (bad configuration), and no read is issued for that level.
- R4: An entry with bit 63 (valid) clear ends the walk with a fault whose cause is 2'b10 (no entry).
- R5: An entry with bit 62 (leaf) set ends the walk. `page_size_o` is the remaining size. `paddr_o` is the leaf's address field with its low `page_size_o` bits cleared, ORed with those low bits of the translated address.
- R6: A walk that needs more than `MAX_LEVELS` entry reads, or a level whose next-level size exceeds the remaining size, ends with a bad-configuration fault (cause 2'b01).
- R7: After a leaf, bit 61 (reference) is set, and on a store also bit 60 (change). The entry is written back to its own address only if it differs from the value read. Otherwise no write is issued.
- R8: On success `write_ok_o` equals the request's store flag, so a load-only walk withholds write permission.
- R9: `mem_req_o`, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` stay stable until `mem_ack_i`. The result does not depend on the stall length.
- R10: `ready_o` is low from acceptance until completion. A `req_i` seen while busy is ignored.
- R11: `done_o` and `fault_o` each pulse for exactly one cycle, never together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a walk (taken only when ready) |
| store_i | input | 1 | Access is a store |
| root_base_i | input | 64 | Root table base address |
| root_nls_i | input | 5 | Root next-level size |
| total_size_i | input | 7 | Total translated size in bits |
| vaddr_i | input | 64 | Address to translate |
| ready_o | output | 1 | Idle, can accept a request |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 64 | Access address |
| mem_wdata_o | output | 64 | Write data |
| mem_ack_i | input | 1 | Access complete (read data valid) |
| mem_rdata_i | input | 64 | Read data |
| done_o | output | 1 | Successful completion pulse |
| fault_o | output | 1 | Faulted completion pulse |
| cause_o | output | 2 | Fault cause: bit0 bad configuration, bit1 no entry |
| paddr_o | output | 64 | Resulting real address |
| page_size_o | output | 7 | log2 of page size |
| write_ok_o | output | 1 | Write permission granted |

## Verification
The assertions assume that the memory side raises `mem_ack_i` only while `mem_req_o` is high, and for a single cycle per access. The bench memory model waits for a request, holds off for a programmable number of cycles, then acknowledges once and drops the acknowledge on the next cycle. Requests are driven only for one cycle at a time, and the tables the bench builds keep total sizes at or below 64 bits, so every shift stays in range.

// File: rtl/radix_walk_pkg.sv
package radix_walk_pkg;
  localparam int unsigned PTE_W     = 64;
  localparam int unsigned VALID_BIT = 63;
  localparam int unsigned LEAF_BIT  = 62;
  localparam int unsigned REF_BIT   = 61;
  localparam int unsigned CHG_BIT   = 60;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_CALC,
    WS_READ,
    WS_WRITE
  } walk_state_e;

  // address field shared by directory base and leaf page number
  function automatic logic [PTE_W-1:0] pte_addr_field(input logic [PTE_W-1:0] pte);
    return {8'h00, pte[55:8], 8'h00};
  endfunction

  function automatic logic [PTE_W-1:0] low_mask(input logic [6:0] bits);
    if (bits >= 7'd64) return '1;
    return (64'd1 << bits) - 64'd1;
  endfunction
endpackage

// File: rtl/radix_index_calc.sv
module radix_index_calc #(
  parameter int unsigned NLS_W   = 5,
  parameter int unsigned SIZE_W  = 7,
  parameter int unsigned MIN_NLS = 5
) (
  input  logic [63:0]       vaddr_i,
  input  logic [63:0]       base_i,
  input  logic [NLS_W-1:0]  nls_i,
  input  logic [SIZE_W-1:0] rem_i,
  output logic [SIZE_W-1:0] rem_next_o,
  output logic [63:0]       entry_addr_o,
  output logic              cfg_bad_o
);
  logic [SIZE_W-1:0] nls_ext;
  logic [63:0]       idx;
  logic [63:0]       idx_mask;

  assign nls_ext    = SIZE_W'(nls_i);
  assign cfg_bad_o  = (nls_i < NLS_W'(MIN_NLS)) || (nls_ext > rem_i);
  assign rem_next_o = rem_i - nls_ext;
  assign idx_mask   = (64'd1 << nls_i) - 64'd1;

  always_comb begin
    idx = (vaddr_i >> rem_next_o) & idx_mask;
    entry_addr_o = base_i + {idx[60:0], 3'b000};
  end
endmodule

// File: rtl/radix_pte_update.sv
module radix_pte_update
  import radix_walk_pkg::*;
(
  input  logic [PTE_W-1:0] pte_i,
  input  logic             store_i,
  output logic [PTE_W-1:0] pte_o,
  output logic             changed_o
);
  always_comb begin
    pte_o = pte_i;
    pte_o[REF_BIT] = 1'b1;
    if (store_i) pte_o[CHG_BIT] = 1'b1;
  end
  assign changed_o = (pte_o != pte_i);
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import radix_walk_pkg::*;
#(
  parameter int unsigned MAX_LEVELS = 4,
  parameter int unsigned NLS_W      = 5,
  parameter int unsigned SIZE_W     = 7,
  parameter int unsigned MIN_NLS    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              store_i,
  input  logic [63:0]       root_base_i,
  input  logic [NLS_W-1:0]  root_nls_i,
  input  logic [SIZE_W-1:0] total_size_i,
  input  logic [63:0]       vaddr_i,
  output logic              ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [63:0]       mem_addr_o,
  output logic [63:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [63:0]       mem_rdata_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [1:0]        cause_o,
  output logic [63:0]       paddr_o,
  output logic [SIZE_W-1:0] page_size_o,
  output logic              write_ok_o
);
  localparam int unsigned LVL_W = $clog2(MAX_LEVELS + 1);

  walk_state_e       state_q;
  logic [63:0]       vaddr_q, base_q, addr_q, entry_q, wdata_q, paddr_q;
  logic [NLS_W-1:0]  nls_q;
  logic [SIZE_W-1:0] rem_q, psize_q;
  logic [LVL_W-1:0]  level_q;
  logic              store_q, done_q, fault_q, wok_q;
  logic [1:0]        cause_q;

  logic [SIZE_W-1:0] rem_next;
  logic [63:0]       entry_addr;
  logic              cfg_bad;
  logic [63:0]       upd_pte;
  logic              upd_changed;
  logic [63:0]       leaf_mask;

  radix_index_calc #(
    .NLS_W  (NLS_W),
    .SIZE_W (SIZE_W),
    .MIN_NLS(MIN_NLS)
  ) u_idx (
    .vaddr_i     (vaddr_q),
    .base_i      (base_q),
    .nls_i       (nls_q),
    .rem_i       (rem_q),
    .rem_next_o  (rem_next),
    .entry_addr_o(entry_addr),
    .cfg_bad_o   (cfg_bad)
  );

  radix_pte_update u_upd (
    .pte_i    (mem_rdata_i),
    .store_i  (store_q),
    .pte_o    (upd_pte),
    .changed_o(upd_changed)
  );

  assign leaf_mask = low_mask(7'(rem_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WS_IDLE;
      vaddr_q <= '0;
      base_q  <= '0;
      addr_q  <= '0;
      entry_q <= '0;
      wdata_q <= '0;
      paddr_q <= '0;
      nls_q   <= '0;
      rem_q   <= '0;
      psize_q <= '0;
      level_q <= '0;
      store_q <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      wok_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (state_q)
        WS_IDLE: if (req_i) begin
          vaddr_q <= vaddr_i;
          base_q  <= root_base_i;
          nls_q   <= root_nls_i;
          rem_q   <= total_size_i;
          store_q <= store_i;
          level_q <= '0;
          cause_q <= '0;
          state_q <= WS_CALC;
        end
        WS_CALC: begin
          if (cfg_bad || level_q == LVL_W'(MAX_LEVELS)) begin
            cause_q <= 2'b01;
            fault_q <= 1'b1;
            state_q <= WS_IDLE;
          end else begin
            addr_q  <= entry_addr;
            rem_q   <= rem_next;
            level_q <= level_q + 1'b1;
            state_q <= WS_READ;
          end
        end
        WS_READ: if (mem_ack_i) begin
          entry_q <= mem_rdata_i;
          if (!mem_rdata_i[VALID_BIT]) begin
            cause_q <= 2'b10;
            fault_q <= 1'b1;
            state_q <= WS_IDLE;
          end else if (mem_rdata_i[LEAF_BIT]) begin
            paddr_q <= (pte_addr_field(mem_rdata_i) & ~leaf_mask) | (vaddr_q & leaf_mask);
            psize_q <= rem_q;
            wok_q   <= store_q;
            wdata_q <= upd_pte;
            if (upd_changed) begin
              state_q <= WS_WRITE;
            end else begin
              done_q  <= 1'b1;
              state_q <= WS_IDLE;
            end
          end else begin
            base_q  <= pte_addr_field(mem_rdata_i);
            nls_q   <= mem_rdata_i[NLS_W-1:0];
            state_q <= WS_CALC;
          end
        end
        WS_WRITE: if (mem_ack_i) begin
          done_q  <= 1'b1;
          state_q <= WS_IDLE;
        end
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  assign ready_o     = (state_q == WS_IDLE);
  assign mem_req_o   = (state_q == WS_READ) || (state_q == WS_WRITE);
  assign mem_we_o    = (state_q == WS_WRITE);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign done_o      = done_q;
  assign fault_o     = fault_q;
  assign cause_o     = cause_q;
  assign paddr_o     = paddr_q;
  assign page_size_o = psize_q;
  assign write_ok_o  = wok_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  fault_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o);
  // R11
  done_fault_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));
  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                   && $stable(mem_we_o) && $stable(mem_wdata_o)));
  // R7
  wb_changed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wdata_o != entry_q) && mem_wdata_o[REF_BIT]);
  // R3
  read_nls_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) && !mem_we_o |-> $past(nls_q) >= NLS_W'(MIN_NLS));
  // R6
  depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LVL_W'(MAX_LEVELS));
  // R10
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !ready_o);
endmodule

// File: tb/tb_radix_walker.sv
module tb_radix_walker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, store_i = 1'b0;
  logic [63:0] root_base_i = '0, vaddr_i = '0;
  logic [4:0]  root_nls_i = '0;
  logic [6:0]  total_size_i = '0;
  logic        ready_o, mem_req_o, mem_we_o, mem_ack_i = 1'b0;
  logic [63:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0, paddr_o;
  logic        done_o, fault_o, write_ok_o;
  logic [1:0]  cause_o;
  logic [6:0]  page_size_o;

  int tests = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, mem_delay = 0;
  logic [63:0] mem [logic [63:0]];
  logic [63:0] lvl_base [0:7];
  logic [4:0]  lvl_nls  [0:7];
  logic [63:0] leaf_addr;
  int          leaf_rem;

  always #4 clk_i = ~clk_i;

  radix_walker dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_dir(input logic [63:0] b, input logic [4:0] n);
    return 64'h8000_0000_0000_0000 | (b & 64'h00FF_FFFF_FFFF_FF00) | 64'(n);
  endfunction
  function automatic logic [63:0] mk_leaf(input logic [63:0] p, input logic r, input logic c);
    return 64'hC000_0000_0000_0000 | ({2'b0, r, c, 60'b0}) | (p & 64'h00FF_FFFF_FFFF_FF00);
  endfunction

  // memory model: stalls mem_delay cycles, acks one cycle
  initial forever begin
    @(negedge clk_i);
    mem_ack_i = 1'b0;
    if (mem_req_o) begin
      repeat (mem_delay) @(negedge clk_i);
      if (mem_we_o) begin
        mem[mem_addr_o] = mem_wdata_o;
        wr_cnt++;
      end else begin
        mem_rdata_i = mem.exists(mem_addr_o) ? mem[mem_addr_o] : 64'h0;
        rd_cnt++;
      end
      mem_ack_i = 1'b1;
    end
  end

  // writes n entries along the path of va; the last is a leaf
  task automatic build(input logic [63:0] va, input int total, input int n,
                       input logic [63:0] page, input logic r, input logic c);
    int rem = total;
    mem.delete();
    for (int i = 0; i < n; i++) begin
      logic [63:0] a;
      rem -= int'(lvl_nls[i]);
      a = lvl_base[i] + (((va >> rem) & ((64'd1 << lvl_nls[i]) - 1)) << 3);
      if (i == n - 1) begin
        mem[a] = mk_leaf(page, r, c);
        leaf_addr = a;
        leaf_rem = rem;
      end else mem[a] = mk_dir(lvl_base[i+1], lvl_nls[i+1]);
    end
  endtask

  task automatic start(input logic [63:0] va, input int total, input logic st);
    @(negedge clk_i);
    req_i = 1'b1; store_i = st; vaddr_i = va;
    root_base_i = lvl_base[0]; root_nls_i = lvl_nls[0]; total_size_i = 7'(total);
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  // waits for completion; returns 1 on done, 0 on fault
  task automatic finish_wait(output bit ok);
    int n = 0;
    ok = 1'b0;
    while (!(done_o || fault_o) && n < 3000) begin @(negedge clk_i); n++; end
    if (n >= 3000) begin check("R11 timeout", 0, 1); return; end
    ok = done_o;
    @(negedge clk_i);
    check("R11 single pulse", {62'b0, done_o, fault_o}, 64'd0);
  endtask

  function automatic logic [63:0] exp_pa(input logic [63:0] page, input logic [63:0] va, input int rem);
    logic [63:0] m = (64'd1 << rem) - 1;
    return ((page & 64'h00FF_FFFF_FFFF_FF00) & ~m) | (va & m);
  endfunction

  localparam logic [63:0] VA = 64'h0000_1234_5678_9ABC;
  localparam logic [63:0] PG = 64'h0000_00AB_CDEF_5000;

  task automatic setup4();
    lvl_base[0] = 64'h1_0000; lvl_base[1] = 64'h2_0000;
    lvl_base[2] = 64'h3_0000; lvl_base[3] = 64'h4_0000;
    for (int i = 0; i < 4; i++) lvl_nls[i] = 5'd9;
  endtask

  task automatic t_reset();
    check("R1 ready", ready_o, 1);
    check("R1 done/fault/req", {61'b0, done_o, fault_o, mem_req_o}, 0);
  endtask

  task automatic t_load4();
    bit ok; int r0;
    setup4(); build(VA, 48, 4, PG, 0, 0);
    r0 = rd_cnt;
    start(VA, 48, 0); finish_wait(ok);
    check("R2 four reads along path", rd_cnt - r0, 4);
    check("R5 done", ok, 1);
    check("R5 paddr", paddr_o, exp_pa(PG, VA, 12));
    check("R5 page size", page_size_o, 12);
    check("R7 ref set, no change", mem[leaf_addr], mk_leaf(PG, 1, 0));
    check("R8 load withholds write", write_ok_o, 0);
  endtask

  task automatic t_store();
    bit ok; int w0 = wr_cnt;
    start(VA, 48, 1); finish_wait(ok);
    check("R7 store sets change", mem[leaf_addr], mk_leaf(PG, 1, 1));
    check("R7 one write", wr_cnt - w0, 1);
    check("R8 store grants write", write_ok_o, 1);
  endtask

  task automatic t_no_wb();
    bit ok; int w0 = wr_cnt;
    start(VA, 48, 1); finish_wait(ok);
    check("R7 unchanged entry not written", wr_cnt - w0, 0);
    check("R7 done", ok, 1);
  endtask

  task automatic t_large();
    bit ok;
    setup4(); lvl_nls[0] = 13; lvl_nls[1] = 14;
    build(VA, 48, 2, PG, 1, 0);
    start(VA, 48, 0); finish_wait(ok);
    check("R5 large page size", page_size_o, 21);
    check("R5 large paddr", paddr_o, exp_pa(PG, VA, 21));
  endtask

  task automatic t_badcfg();
    bit ok; int r0;
    setup4(); lvl_nls[1] = 5'd4;
    build(VA, 48, 3, PG, 0, 0);
    r0 = rd_cnt;
    start(VA, 48, 0); finish_wait(ok);
    check("R3 dir nls<5 fault", {ok, cause_o}, {1'b0, 2'b01});
    check("R3 no read for bad level", rd_cnt - r0, 1);
    setup4(); lvl_nls[0] = 5'd4;
    r0 = rd_cnt;
    start(VA, 48, 0); finish_wait(ok);
    check("R3 root nls<5 no read", rd_cnt - r0, 0);
    check("R3 root cause", cause_o, 2'b01);
  endtask

  task automatic t_invalid();
    bit ok;
    setup4(); mem.delete();
    start(VA, 48, 0); finish_wait(ok);
    check("R4 invalid entry", {ok, cause_o}, {1'b0, 2'b10});
  endtask

  task automatic t_depth();
    bit ok; int r0;
    setup4(); lvl_base[4] = 64'h5_0000;
    for (int i = 0; i < 5; i++) lvl_nls[i] = 5'd5;
    build(VA, 40, 5, PG, 0, 0);
    r0 = rd_cnt;
    start(VA, 40, 0); finish_wait(ok);
    check("R6 depth limit fault", {ok, cause_o}, {1'b0, 2'b01});
    check("R6 reads before depth fault", rd_cnt - r0, 4);
    setup4(); lvl_nls[0] = 5'd13;
    start(VA, 12, 0); finish_wait(ok);
    check("R6 nls above remaining", {ok, cause_o}, {1'b0, 2'b01});
  endtask

  task automatic t_stall();
    bit ok;
    setup4(); build(VA, 48, 4, PG, 1, 0);
    mem_delay = 7;
    start(VA, 48, 0); finish_wait(ok);
    mem_delay = 0;
    check("R9 stalled paddr", paddr_o, exp_pa(PG, VA, 12));
    check("R9 stalled done", ok, 1);
  endtask

  task automatic t_busy();
    bit ok;
    setup4(); build(VA, 48, 4, PG, 1, 0);
    mem_delay = 3;
    start(VA, 48, 0);
    check("R10 busy not ready", ready_o, 0);
    @(negedge clk_i);
    req_i = 1'b1; vaddr_i = 64'hFFFF_0000_0000_0000; store_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    finish_wait(ok);
    mem_delay = 0;
    check("R10 busy request ignored", paddr_o, exp_pa(PG, VA, 12));
    check("R10 store flag from first", write_ok_o, 0);
    repeat (3) @(negedge clk_i);
    check("R10 idle after", {63'b0, ready_o}, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    check("watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_load4();
    t_store();
    t_no_wb();
    t_large();
    t_badcfg();
    t_invalid();
    t_depth();
    t_stall();
    t_busy();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule